// File: doc/BRIEF.md
# Branch Direction Predictor with Selectable Scheme

This block guesses, at fetch time, whether a conditional branch will be taken. A two-bit scheme input picks one of four policies at run time. The first always guesses not-taken. The second guesses taken for a backward branch, which has a negative displacement. The third copies a direction hint bit that the compiler placed in the instruction. The fourth reads a small direct-mapped table of branch history.

The table is indexed by a slice of the fetch address and holds no tag. Branches whose addresses agree in that slice therefore share one entry. A run-time select decides how each entry behaves. It either remembers the most recent outcome, or it acts as a two-bit saturating counter that changes its guess only after two wrong outcomes in a row.

The resolve port reports a branch's address and its real direction, and the entry is updated on the next clock edge. The guess is combinational from the fetch inputs and the current table. Target address generation is handled elsewhere.

Top module: `bp_predictor`

## Requirements
- R1: After reset every table entry guesses not-taken in both entry formats. Two-bit entries start in state 1 (weakly not-taken).
- R2: When `fe_valid` is low, `pred_taken` is 0 whatever the other inputs are.
- R3: With `mode` = 0 the guess is always not-taken.
- R4: With `mode` = 1 the guess equals `fe_disp_neg`: 1 (negative displacement) gives taken and 0 gives not-taken.
- R5: With `mode` = 2 the guess equals `fe_hint`.
- R6: With `mode` = 3 the entry is selected by `fe_pc[PC_LSB+IDX_W-1:PC_LSB]`, which is bits 5:2 by default. No tag is compared, so two addresses that agree in those bits read and train the same entry.
- R7: With `two_bit` = 0 an entry holds the last outcome reported for its index, and the guess repeats that outcome.
- R8: With `two_bit` = 1 an entry is a counter from 0 to 3. A taken report adds one and saturates at 3. A not-taken report subtracts one and saturates at 0. States 2 and 3 guess taken.
- R9: An update is written on the clock edge. A lookup at the same index in the same cycle returns the value from before the update, and the new value is seen from the next cycle.
- R10: A valid update trains the table in every mode. The trained value is what a later lookup in mode 3 returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Scheme: 0 never, 1 backward-taken, 2 hint, 3 table |
| two_bit | input | 1 | Table entry format: 1 counter, 0 last outcome |
| fe_valid | input | 1 | A conditional branch is at fetch |
| fe_pc | input | PC_W | Fetch address of the branch |
| fe_disp_neg | input | 1 | Sign of the branch displacement (1 = backward) |
| fe_hint | input | 1 | Compiler direction hint (1 = taken) |
| upd_valid | input | 1 | A branch has resolved |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Real direction of the resolved branch |
| pred_taken | output | 1 | Guess for the fetched branch |

## Verification
The guess is combinational, so it is due in the same cycle as its fetch inputs. The bench drives the inputs on the falling edge and compares the guess one nanosecond later. A resolve report changes the table at the next rising edge, and the first lookup that can see it is in the cycle after that edge. The bench's reference table is therefore updated only after the rising edge, which means a lookup and an update at the same index in one cycle are checked against the old value. Every cycle is compared, in directed runs for each scheme and in random runs for both entry formats.

// File: rtl/bp_pkg.sv
package bp_pkg;
    typedef enum logic [1:0] {
        PM_NEVER = 2'd0,
        PM_SIGN  = 2'd1,
        PM_HINT  = 2'd2,
        PM_TABLE = 2'd3
    } pmode_e;

    localparam logic [1:0] CTR_WEAK_NT = 2'b01;
    localparam logic [1:0] CTR_MAX     = 2'b11;
    localparam logic [1:0] CTR_MIN     = 2'b00;
endpackage

// File: rtl/bp_ctr_next.sv
module bp_ctr_next
    import bp_pkg::*;
(
    input  logic [1:0] cur,
    input  logic       taken,
    input  logic       wide,
    output logic [1:0] nxt
);
    always_comb begin
        if (!wide) begin
            // last-outcome entry: both bits hold the outcome
            nxt = {taken, taken};
        end else if (taken) begin
            nxt = (cur == CTR_MAX) ? CTR_MAX : cur + 2'd1;
        end else begin
            nxt = (cur == CTR_MIN) ? CTR_MIN : cur - 2'd1;
        end
    end
endmodule

// File: rtl/bp_static.sv
module bp_static
    import bp_pkg::*;
(
    input  pmode_e mode,
    input  logic   disp_neg,
    input  logic   hint,
    output logic   guess
);
    always_comb begin
        unique case (mode)
            PM_SIGN: guess = disp_neg;
            PM_HINT: guess = hint;
            default: guess = 1'b0;
        endcase
    end
endmodule

// File: rtl/bp_hist_table.sv
module bp_hist_table
    import bp_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             two_bit,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    localparam int N = 1 << IDX_W;

    typedef struct packed {
        logic [N-1:0][1:0] ctr;
    } tbl_s;

    tbl_s       st_d, st_q;
    logic [1:0] wr_cur, wr_nxt;

    assign wr_cur = st_q.ctr[wr_idx];

    bp_ctr_next u_next (
        .cur  (wr_cur),
        .taken(wr_taken),
        .wide (two_bit),
        .nxt  (wr_nxt)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ctr[wr_idx] = wr_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= tbl_s'({N{CTR_WEAK_NT}});
        end else begin
            st_q <= st_d;
        end
    end

    // read returns the registered value, never the pending write
    assign rd_taken = st_q.ctr[rd_idx][1];

    // R8
    ctr_sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && two_bit && wr_taken && st_q.ctr[wr_idx] == CTR_MAX)
        |=> st_q.ctr[$past(wr_idx)] == CTR_MAX);

    // R8
    ctr_sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && two_bit && !wr_taken && st_q.ctr[wr_idx] == CTR_MIN)
        |=> st_q.ctr[$past(wr_idx)] == CTR_MIN);

    // R7
    one_bit_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !two_bit)
        |=> st_q.ctr[$past(wr_idx)][1] == $past(wr_taken));
endmodule

// File: rtl/bp_predictor.sv
module bp_predictor
    import bp_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int IDX_W  = 4,
    parameter int PC_LSB = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode,
    input  logic            two_bit,
    input  logic            fe_valid,
    input  logic [PC_W-1:0] fe_pc,
    input  logic            fe_disp_neg,
    input  logic            fe_hint,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    output logic            pred_taken
);
    pmode_e           mode_e;
    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic             tbl_guess, stat_guess;

    assign mode_e = pmode_e'(mode);
    assign rd_idx = fe_pc[PC_LSB +: IDX_W];
    assign wr_idx = upd_pc[PC_LSB +: IDX_W];

    bp_static u_static (
        .mode    (mode_e),
        .disp_neg(fe_disp_neg),
        .hint    (fe_hint),
        .guess   (stat_guess)
    );

    bp_hist_table #(.IDX_W(IDX_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .two_bit (two_bit),
        .rd_idx  (rd_idx),
        .rd_taken(tbl_guess),
        .wr_en   (upd_valid),
        .wr_idx  (wr_idx),
        .wr_taken(upd_taken)
    );

    always_comb begin
        if (!fe_valid) begin
            pred_taken = 1'b0;
        end else if (mode_e == PM_TABLE) begin
            pred_taken = tbl_guess;
        end else begin
            pred_taken = stat_guess;
        end
    end

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fe_valid |-> !pred_taken);

    // R3
    never_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |-> !pred_taken);

    // R4
    sign_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_valid && mode == 2'd1) |-> pred_taken == fe_disp_neg);

    // R5
    hint_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_valid && mode == 2'd2) |-> pred_taken == fe_hint);
endmodule

// File: tb/bp_predictor_bench.sv
module bp_predictor_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        two_bit = 1'b0;
    logic        fe_valid = 1'b0;
    logic [31:0] fe_pc = '0;
    logic        fe_disp_neg = 1'b0;
    logic        fe_hint = 1'b0;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic        pred_taken;

    int total = 0;
    int bad = 0;
    int ref_ctr [16];

    always #4 clk = ~clk;

    bp_predictor u_bp_predictor (
        .clk(clk), .rst_n(rst_n), .mode(mode), .two_bit(two_bit),
        .fe_valid(fe_valid), .fe_pc(fe_pc), .fe_disp_neg(fe_disp_neg),
        .fe_hint(fe_hint), .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_taken(upd_taken), .pred_taken(pred_taken)
    );

    function automatic int idx_of(logic [31:0] pc);
        return int'((pc >> 2) & 32'hF);
    endfunction

    function automatic logic expect_guess();
        if (!fe_valid) return 1'b0;
        case (mode)
            2'd0: return 1'b0;
            2'd1: return fe_disp_neg;
            2'd2: return fe_hint;
            default: return ref_ctr[idx_of(fe_pc)] >= 2;
        endcase
    endfunction

    task automatic set_in(input logic [1:0] m, input logic v, input logic [31:0] pc,
                          input logic dn, input logic h, input logic uv,
                          input logic [31:0] upc, input logic ut);
        mode = m; fe_valid = v; fe_pc = pc; fe_disp_neg = dn; fe_hint = h;
        upd_valid = uv; upd_pc = upc; upd_taken = ut;
    endtask

    // compare now, then advance one clock and update the model
    task automatic cyc(input string tag);
        logic exp_v;
        #1;
        exp_v = expect_guess();
        total++;
        if (pred_taken !== exp_v) begin
            bad++;
            $display("FAIL %s: pred_taken=%b expected=%b (mode=%0d pc=%h)",
                     tag, pred_taken, exp_v, mode, fe_pc);
        end
        @(posedge clk);
        if (upd_valid) begin
            int i = idx_of(upd_pc);
            if (two_bit) begin
                if (upd_taken) ref_ctr[i] = (ref_ctr[i] == 3) ? 3 : ref_ctr[i] + 1;
                else           ref_ctr[i] = (ref_ctr[i] == 0) ? 0 : ref_ctr[i] - 1;
            end else begin
                ref_ctr[i] = upd_taken ? 3 : 0;
            end
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        set_in(2'd0, 1'b0, '0, 1'b0, 1'b0, 1'b0, '0, 1'b0);
        repeat (3) @(negedge clk);
        for (int i = 0; i < 16; i++) ref_ctr[i] = 1;
        rst_n = 1'b1;
    endtask

    task automatic train(input logic [31:0] pc, input logic t, input string tag);
        set_in(2'd3, 1'b1, pc, 1'b0, 1'b0, 1'b1, pc, t);
        cyc(tag);
    endtask

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state, one-bit then two-bit format
        two_bit = 1'b0;
        do_reset();
        for (int i = 0; i < 16; i++) begin
            set_in(2'd3, 1'b1, 32'(i * 4), 1'b0, 1'b0, 1'b0, '0, 1'b0);
            cyc("R1");
        end
        two_bit = 1'b1;
        do_reset();
        for (int i = 0; i < 16; i++) begin
            set_in(2'd3, 1'b1, 32'(i * 4), 1'b0, 1'b0, 1'b0, '0, 1'b0);
            cyc("R1");
        end

        // R2: invalid fetch in each mode
        for (int m = 0; m < 4; m++) begin
            set_in(2'(m), 1'b0, 32'h10, 1'b1, 1'b1, 1'b0, '0, 1'b0);
            cyc("R2");
        end

        // R3, R4, R5: static schemes over both input values
        for (int k = 0; k < 4; k++) begin
            set_in(2'd0, 1'b1, 32'(k * 4), k[0], k[1], 1'b0, '0, 1'b0);
            cyc("R3");
            set_in(2'd1, 1'b1, 32'(k * 4), k[0], k[1], 1'b0, '0, 1'b0);
            cyc("R4");
            set_in(2'd2, 1'b1, 32'(k * 4), k[0], k[1], 1'b0, '0, 1'b0);
            cyc("R5");
        end

        // R8: counter saturation and hysteresis at index 3
        two_bit = 1'b1;
        do_reset();
        train(32'h0C, 1'b1, "R8");   // 1 -> 2
        train(32'h0C, 1'b1, "R8");   // 2 -> 3
        train(32'h0C, 1'b1, "R8");   // stays 3
        train(32'h0C, 1'b0, "R8");   // 3 -> 2, still taken
        train(32'h0C, 1'b0, "R8");   // 2 -> 1, flips
        train(32'h0C, 1'b0, "R8");   // 1 -> 0
        train(32'h0C, 1'b0, "R8");   // stays 0
        train(32'h0C, 1'b1, "R8");   // 0 -> 1, still not taken
        set_in(2'd3, 1'b1, 32'h0C, 1'b0, 1'b0, 1'b0, '0, 1'b0);
        cyc("R8");

        // R6: aliasing, 0x44 and 0x04 share index 1
        train(32'h44, 1'b1, "R6");
        train(32'h44, 1'b1, "R6");
        set_in(2'd3, 1'b1, 32'h04, 1'b0, 1'b0, 1'b0, '0, 1'b0);
        cyc("R6");
        set_in(2'd3, 1'b1, 32'h08, 1'b0, 1'b0, 1'b0, '0, 1'b0);
        cyc("R6");

        // R9: same-cycle lookup and update at index 5
        set_in(2'd3, 1'b1, 32'h14, 1'b0, 1'b0, 1'b1, 32'h14, 1'b1);
        cyc("R9");
        set_in(2'd3, 1'b1, 32'h14, 1'b0, 1'b0, 1'b1, 32'h14, 1'b1);
        cyc("R9");
        set_in(2'd3, 1'b1, 32'h14, 1'b0, 1'b0, 1'b0, '0, 1'b0);
        cyc("R9");

        // R10: training under mode 0, read under mode 3, index 7
        set_in(2'd0, 1'b1, 32'h1C, 1'b0, 1'b0, 1'b1, 32'h1C, 1'b1);
        cyc("R10");
        set_in(2'd2, 1'b1, 32'h1C, 1'b0, 1'b0, 1'b1, 32'h1C, 1'b1);
        cyc("R10");
        set_in(2'd3, 1'b1, 32'h1C, 1'b0, 1'b0, 1'b0, '0, 1'b0);
        cyc("R10");

        // R7: one-bit format follows the last outcome at index 9
        two_bit = 1'b0;
        do_reset();
        train(32'h24, 1'b1, "R7");
        train(32'h24, 1'b0, "R7");
        train(32'h24, 1'b1, "R7");
        set_in(2'd3, 1'b1, 32'h24, 1'b0, 1'b0, 1'b0, '0, 1'b0);
        cyc("R7");

        // random traffic in both formats
        for (int f = 0; f < 2; f++) begin
            two_bit = f[0];
            do_reset();
            for (int n = 0; n < 400; n++) begin
                set_in(2'($urandom_range(3)), 1'($urandom_range(7) != 0),
                       32'($urandom_range(255)) << 2, 1'($urandom),
                       1'($urandom), 1'($urandom_range(3) != 0),
                       32'($urandom_range(255)) << 2, 1'($urandom));
                cyc(f[0] ? "R8 random" : "R7 random");
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule